// File: doc/BRIEF.md
# Watchdog Supervisor with Qualified Reset

This block watches over a processor from the oscillator clock domain. An 8-bit watchdog timer advances once per prescaler wrap. The prescaler advances once per machine cycle of twelve oscillator periods. A dedicated enable pin starts the count. Software keeps the watchdog quiet by reloading the timer through a two-step strobe sequence: an arm strobe, then in the very next cycle a load strobe carrying the new timer value. If the timer passes its all-ones value, the block drives a reset pulse onto the reset pin for two machine cycles.

The same block filters the incoming reset pin. A level on the pin becomes an internal reset only after it has been seen high on 24 consecutive oscillator edges, so glitches and short spikes are rejected. The internal reset is the OR of this qualified external reset and the watchdog pulse, and it returns all watchdog state to zero. While the enable pin is high, the block also refuses any power-down request.

Control sits in a three-state machine. `ST_IDLE` holds the timer and prescaler at zero and moves to `ST_COUNT` when the enable pin is high. `ST_COUNT` counts and accepts reloads. It returns to `ST_IDLE` when the enable pin drops, and moves to `ST_PULSE` on timer overflow. `ST_PULSE` drives the reset pin and returns to `ST_IDLE` after 24 cycles. A qualified external reset forces `ST_IDLE` from any state.

Top module: `wdt_supervisor`

## Requirements
- R1: `sys_rst` rises only after `rst_pin_in` has been sampled high on 24 consecutive rising clock edges. A high level lasting 23 edges never raises it.
- R2: Once `rst_pin_in` has been low for one edge after a qualified reset, with no pulse pending, `sys_rst` and `rst_pin_out` are both low.
- R3: While `wd_en_pin` is low, the timer does not advance and no reset pulse is produced, for any length of time.
- R4: A reload of value V sets the timer to V and clears the prescaler. The reset pulse then first appears 12·2^PRESC_W·(2^TMR_W − V) clock edges after the reload edge (288 edges for V = 250 with PRESC_W = 2).
- R5: Each watchdog reset pulse on `rst_pin_out` stays high for exactly 24 clock cycles.
- R6: `sys_rst` is high in every cycle in which `rst_pin_out` is high.
- R7: A load strobe is taken only if `kick_arm` was high on the edge just before it. A load without an arm, or one cycles after the arm, leaves the timer unchanged.
- R8: After a pulse, the timer and prescaler restart from zero. With `wd_en_pin` held high, the next pulse rises 12·2^PRESC_W·2^TMR_W + 1 edges after the edge on which the previous pulse ended.
- R9: `pd_grant` follows `pd_req` while `wd_en_pin` is low and no reset is active. It is held low whenever `wd_en_pin` is high.
- R10: Armed reloads repeated more often than the overflow interval prevent any reset pulse.
- R11: A qualified external reset during counting clears the timer. The next pulse rises 12·2^PRESC_W·2^TMR_W + 1 edges after the edge on which the external reset released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| wd_en_pin | input | 1 | Watchdog enable pin; also vetoes power-down |
| rst_pin_in | input | 1 | Level sensed on the reset pin |
| rst_pin_out | output | 1 | Reset pulse driven onto the reset pin on overflow |
| kick_arm | input | 1 | First strobe of the reload sequence |
| kick_load | input | 1 | Second strobe; loads `kick_value` when armed |
| kick_value | input | TMR_W | Reload value for the timer |
| pd_req | input | 1 | Power-down request |
| pd_grant | output | 1 | Power-down permitted |
| sys_rst | output | 1 | Internal reset (qualified pin or watchdog pulse) |

## Verification
The reload path is tried with two near-overflow values and with a full-length count from zero. The two near-overflow values show that each timer step costs one full prescaler wrap. The full-length count, started both after a pulse and after an external reset, shows that every piece of state was really cleared. Unarmed loads and loads whose arm strobe came two cycles early are mixed into an armed countdown: only a correct arm check leaves the overflow time where the armed load put it. Reset pin widths of 23 and 24 edges separate a correct qualifier from an off-by-one one. A long disabled window with a power-down request pending shows both the enable gating and the veto.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2
    } wdt_state_e;
endpackage

// File: rtl/wdt_rst_qual.sv
// Reset pin qualifier: a level becomes a reset after RST_MIN consecutive high samples.
module wdt_rst_qual #(
    parameter int RST_MIN = 24
) (
    input  logic clk,
    input  logic pin_in,
    output logic qual
);
    localparam int CW = $clog2(RST_MIN + 1);
    localparam logic [CW-1:0] QMAX = CW'(RST_MIN);

    logic [CW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!pin_in)
            run_len <= '0;
        else if (run_len != QMAX)
            run_len <= run_len + 1'b1;
    end

    assign qual = (run_len == QMAX);
endmodule

// File: rtl/wdt_prescaler.sv
// Machine-cycle divider plus binary prescaler; carry marks one timer step.
module wdt_prescaler #(
    parameter int OSC_PER_MC = 12,
    parameter int PRESC_W    = 11
) (
    input  logic clk,
    input  logic clr,
    input  logic run,
    output logic carry
);
    localparam int MCW = $clog2(OSC_PER_MC);
    localparam logic [MCW-1:0] MC_LAST = MCW'(OSC_PER_MC - 1);

    logic [MCW-1:0]     mc_cnt;
    logic [PRESC_W-1:0] presc;
    logic               mc_tick;

    assign mc_tick = (mc_cnt == MC_LAST);

    always_ff @(posedge clk) begin
        if (clr || !run) begin
            mc_cnt <= '0;
            presc  <= '0;
        end else if (mc_tick) begin
            mc_cnt <= '0;
            presc  <= presc + 1'b1;
        end else begin
            mc_cnt <= mc_cnt + 1'b1;
        end
    end

    assign carry = run && !clr && mc_tick && (&presc);
endmodule

// File: rtl/wdt_timer.sv
// Watchdog timer with two-step reload sequence and overflow detection.
module wdt_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             run,
    input  logic             carry,
    input  logic             arm,
    input  logic             load,
    input  logic [TMR_W-1:0] value,
    output logic             reload_ok,
    output logic             ovf
);
    logic             arm_q;
    logic [TMR_W-1:0] tmr;

    assign reload_ok = run && load && arm_q;

    always_ff @(posedge clk) begin
        if (clr)
            arm_q <= 1'b0;
        else
            arm_q <= arm;
    end

    always_ff @(posedge clk) begin
        if (clr || !run)
            tmr <= '0;
        else if (reload_ok)
            tmr <= value;
        else if (carry)
            tmr <= tmr + 1'b1;
    end

    assign ovf = carry && (&tmr) && !reload_ok;
endmodule

// File: rtl/wdt_pulse_fsm.sv
// Control state machine: idle / counting / driving the reset pulse.
module wdt_pulse_fsm
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 24
) (
    input  logic clk,
    input  logic ext_qual,
    input  logic en,
    input  logic ovf,
    output logic run,
    output logic pulse
);
    localparam int PW = $clog2(PULSE_LEN);
    localparam logic [PW-1:0] P_LAST = PW'(PULSE_LEN - 1);

    wdt_state_e    state, nxt;
    logic [PW-1:0] pls_cnt;

    // state register
    always_ff @(posedge clk) begin
        if (ext_qual)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (state != ST_PULSE)
            pls_cnt <= '0;
        else
            pls_cnt <= pls_cnt + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (en) nxt = ST_COUNT;
            ST_COUNT: begin
                if (!en)      nxt = ST_IDLE;
                else if (ovf) nxt = ST_PULSE;
            end
            ST_PULSE: if (pls_cnt == P_LAST) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run   = (state == ST_COUNT);
        pulse = (state == ST_PULSE);
    end
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
    parameter int OSC_PER_MC = 12,
    parameter int RST_MC     = 2,
    parameter int PRESC_W    = 11,
    parameter int TMR_W      = 8
) (
    input  logic             clk,
    input  logic             wd_en_pin,
    input  logic             rst_pin_in,
    output logic             rst_pin_out,
    input  logic             kick_arm,
    input  logic             kick_load,
    input  logic [TMR_W-1:0] kick_value,
    input  logic             pd_req,
    output logic             pd_grant,
    output logic             sys_rst
);
    localparam int RST_MIN   = OSC_PER_MC * RST_MC;
    localparam int PULSE_LEN = OSC_PER_MC * RST_MC;

    logic ext_qual, run, pulse, carry, reload_ok, ovf;

    wdt_rst_qual #(.RST_MIN(RST_MIN)) u_qual (
        .clk    (clk),
        .pin_in (rst_pin_in),
        .qual   (ext_qual)
    );

    wdt_prescaler #(.OSC_PER_MC(OSC_PER_MC), .PRESC_W(PRESC_W)) u_presc (
        .clk   (clk),
        .clr   (sys_rst || reload_ok),
        .run   (run),
        .carry (carry)
    );

    wdt_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk       (clk),
        .clr       (sys_rst),
        .run       (run),
        .carry     (carry),
        .arm       (kick_arm),
        .load      (kick_load),
        .value     (kick_value),
        .reload_ok (reload_ok),
        .ovf       (ovf)
    );

    wdt_pulse_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk      (clk),
        .ext_qual (ext_qual),
        .en       (wd_en_pin),
        .ovf      (ovf),
        .run      (run),
        .pulse    (pulse)
    );

    assign sys_rst     = ext_qual || pulse;
    assign rst_pin_out = pulse;
    assign pd_grant    = pd_req && !wd_en_pin && !sys_rst;
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk #(
    parameter int RST_MIN   = 24,
    parameter int PULSE_LEN = 24
) (
    input logic clk,
    input logic wd_en_pin,
    input logic rst_pin_in,
    input logic rst_pin_out,
    input logic pd_grant,
    input logic sys_rst
);
    logic        live   = 1'b0;
    logic [15:0] in_cnt = '0;
    logic [15:0] hi_cnt = '0;

    always_ff @(posedge clk) begin
        if (sys_rst) live <= 1'b1;
        if (!rst_pin_in)          in_cnt <= '0;
        else if (in_cnt != 16'hFFFF) in_cnt <= in_cnt + 1'b1;
        if (!rst_pin_out)         hi_cnt <= '0;
        else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end

    AST_QUAL_WIDTH: assert property (@(posedge clk) disable iff (!live)
        ($rose(sys_rst) && !rst_pin_out) |-> (in_cnt >= 16'(RST_MIN))); // R1
    AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!live)
        $rose(rst_pin_out) |-> $past(wd_en_pin)); // R3
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!live || rst_pin_in)
        $fell(rst_pin_out) |-> (hi_cnt == 16'(PULSE_LEN))); // R5
    AST_RST_COVERS_PULSE: assert property (@(posedge clk) disable iff (!live)
        rst_pin_out |-> sys_rst); // R6
    AST_PD_VETO: assert property (@(posedge clk) disable iff (!live)
        wd_en_pin |-> !pd_grant); // R9
endmodule

bind wdt_supervisor wdt_supervisor_chk #(
    .RST_MIN   (RST_MIN),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk         (clk),
    .wd_en_pin   (wd_en_pin),
    .rst_pin_in  (rst_pin_in),
    .rst_pin_out (rst_pin_out),
    .pd_grant    (pd_grant),
    .sys_rst     (sys_rst)
);

// File: tb/wdt_supervisor_test.sv
module wdt_supervisor_test;
    localparam int PRESC_W = 2;
    localparam int TMR_W   = 8;
    localparam int STEP    = 12 * (1 << PRESC_W);
    localparam int FULL    = STEP * (1 << TMR_W) + 1;

    logic clk = 1'b0;
    logic wd_en_pin = 1'b0, rst_pin_in = 1'b0, kick_arm = 1'b0, kick_load = 1'b0, pd_req = 1'b0;
    logic [TMR_W-1:0] kick_value = '0;
    logic rst_pin_out, pd_grant, sys_rst;

    always #5 clk = ~clk;

    wdt_supervisor #(.PRESC_W(PRESC_W), .TMR_W(TMR_W)) uut (
        .clk(clk), .wd_en_pin(wd_en_pin), .rst_pin_in(rst_pin_in),
        .rst_pin_out(rst_pin_out), .kick_arm(kick_arm), .kick_load(kick_load),
        .kick_value(kick_value), .pd_req(pd_req), .pd_grant(pd_grant), .sys_rst(sys_rst)
    );

    int vectors = 0, fails = 0, cyc = 0, ref_cyc = 0, pulse_count = 0, hi_len = 0;
    int exp_q[$];
    logic prev_out = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // monitor: pops expected pulse delays from the scoreboard
    always @(negedge clk) begin
        if (rst_pin_out && !prev_out) begin
            pulse_count++;
            hi_len = 1;
            chk(sys_rst == 1'b1, "R6 sys_rst during pulse", int'(sys_rst), 1);
            if (exp_q.size() == 0)
                chk(1'b0, "R3/R10 unexpected pulse", cyc - ref_cyc, -1);
            else begin
                automatic int e = exp_q.pop_front();
                chk(cyc - ref_cyc == e, "R4/R8/R11 pulse delay", cyc - ref_cyc, e);
            end
        end else if (rst_pin_out) begin
            hi_len++;
        end
        if (!rst_pin_out && prev_out) begin
            chk(hi_len == 24, "R5 pulse width", hi_len, 24);
            ref_cyc = cyc;
        end
        prev_out = rst_pin_out;
    end

    task automatic armed_load(input int v, input bit push);
        @(negedge clk) kick_arm = 1'b1;
        @(negedge clk) begin kick_arm = 1'b0; kick_load = 1'b1; kick_value = TMR_W'(v); end
        @(negedge clk) kick_load = 1'b0;
        ref_cyc = cyc;
        if (push) exp_q.push_back(STEP * ((1 << TMR_W) - v));
    endtask

    task automatic wait_pulses(input int n, input int limit, input string req);
        int k = 0;
        while (pulse_count < n && k < limit) begin @(negedge clk); k++; end
        chk(pulse_count >= n, req, pulse_count, n);
        while (rst_pin_out) @(negedge clk);
    endtask

    initial begin
        automatic bit seen = 1'b0;
        repeat (3) @(negedge clk);
        // R1: 23-edge high level is rejected
        rst_pin_in = 1'b1;
        repeat (23) begin @(negedge clk); if (sys_rst) seen = 1'b1; end
        rst_pin_in = 1'b0;
        repeat (3) begin @(negedge clk); if (sys_rst) seen = 1'b1; end
        chk(!seen, "R1 short reset rejected", int'(seen), 0);
        // R1: 24 edges qualify
        rst_pin_in = 1'b1;
        repeat (24) @(negedge clk);
        chk(sys_rst == 1'b1, "R1 reset qualified at 24", int'(sys_rst), 1);
        repeat (5) @(negedge clk);
        rst_pin_in = 1'b0;
        @(negedge clk);
        chk(sys_rst == 1'b0, "R2 sys_rst released", int'(sys_rst), 0);
        chk(rst_pin_out == 1'b0, "R2 no pulse after reset", int'(rst_pin_out), 0);
        // R9: power-down granted while disabled
        pd_req = 1'b1;
        @(negedge clk);
        chk(pd_grant == 1'b1, "R9 pd granted when disabled", int'(pd_grant), 1);
        // R3: long disabled window, with a load attempt, gives no pulse
        armed_load(255, 1'b0);
        repeat (13000) @(negedge clk);
        chk(pulse_count == 0, "R3 disabled no pulse", pulse_count, 0);
        // R9: veto
        wd_en_pin = 1'b1;
        @(negedge clk);
        chk(pd_grant == 1'b0, "R9 pd vetoed when enabled", int'(pd_grant), 0);
        pd_req = 1'b0;
        // R4: armed reload near overflow
        armed_load(250, 1'b1);
        wait_pulses(1, 1000, "R4 pulse after reload 250");
        // R8: next full period counts from zero
        exp_q.push_back(FULL);
        wait_pulses(2, FULL + 100, "R8 full period after pulse");
        wd_en_pin = 1'b0;
        repeat (3) @(negedge clk);
        // R4: second reload value
        wd_en_pin = 1'b1;
        repeat (2) @(negedge clk);
        armed_load(200, 1'b1);
        wait_pulses(3, 3000, "R4 pulse after reload 200");
        wd_en_pin = 1'b0;
        repeat (3) @(negedge clk);
        // R7: unarmed and late loads are ignored
        wd_en_pin = 1'b1;
        repeat (2) @(negedge clk);
        armed_load(250, 1'b1);
        repeat (50) @(negedge clk);
        kick_value = '0; kick_load = 1'b1;
        @(negedge clk) kick_load = 1'b0;
        repeat (20) @(negedge clk);
        kick_arm = 1'b1;
        @(negedge clk) kick_arm = 1'b0;
        @(negedge clk) kick_load = 1'b1;
        @(negedge clk) kick_load = 1'b0;
        wait_pulses(4, 1000, "R7 ignored loads keep overflow time");
        wd_en_pin = 1'b0;
        repeat (3) @(negedge clk);
        // R10: periodic kicks prevent overflow
        wd_en_pin = 1'b1;
        for (int i = 0; i < 6; i++) begin
            armed_load(250, 1'b0);
            repeat (200) @(negedge clk);
        end
        wd_en_pin = 1'b0;
        chk(pulse_count == 4, "R10 kicks prevent pulse", pulse_count, 4);
        repeat (3) @(negedge clk);
        // R11: external reset while counting clears the timer
        wd_en_pin = 1'b1;
        armed_load(200, 1'b0);
        repeat (100) @(negedge clk);
        rst_pin_in = 1'b1;
        repeat (24) @(negedge clk);
        chk(sys_rst == 1'b1, "R11 external reset taken", int'(sys_rst), 1);
        rst_pin_in = 1'b0;
        @(negedge clk);
        ref_cyc = cyc;
        exp_q.push_back(FULL);
        wait_pulses(5, FULL + 100, "R11 full period after external reset");
        wd_en_pin = 1'b0;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", cyc, 0);
            finish_run();
        end
    end
endmodule